// File: doc/BRIEF.md
# Vertex Stream Pump

The pump reads vertex records out of an attached single-port RAM and sends one coordinate triple per vertex on a valid/ready stream. A processor sets it up through an AXI4-Lite register port. It writes the number of vertices and a frame-buffer base address, then writes a start bit. It polls a busy/done status word to learn when the run has finished. When a run is accepted, the base address is copied to a plain output that a downstream drawing stage uses.

A vertex occupies four consecutive RAM words. The word at offset 0 holds x, offset 1 holds y and offset 2 holds z. Offset 3 is padding and is never read. Each coordinate word is a signed integer. The pump clamps it to a 22-bit signed range, divides it by 1024 rounding toward minus infinity, and packs the three results into one beat. The RAM returns data one cycle after the address. The pump therefore spends two cycles on each coordinate and one or more on the emit, and it holds the beat for as long as the consumer stalls.

Register map, with 32-bit words and full-word writes:
- 0x0: control and status. Writing a 1 to bit 0 starts a run. A read returns bit 0 = busy and bit 1 = done.
- 0x4: vertex count.
- 0x8: frame-buffer base address.

Top module: `vtx_pump`

## Requirements
- R1: After reset, pt_tvalid_o, ram_en_o and fb_addr_o are 0, and the status word at 0x0 reads 0.
- R2: The vertex count at 0x4 and the frame-buffer base at 0x8 read back exactly the 32-bit value last written.
- R3: When a start is accepted while idle, fb_addr_o takes the base register value on that clock edge and holds it for the rest of the run.
- R4: A run with count N emits exactly N beats, in vertex order. Beat k is built from RAM words 4k, 4k+1 and 4k+2, with the address taken modulo the RAM depth. Exactly 3N RAM reads are made, and none is at an address whose two low bits are 11.
- R5: Each coordinate equals floor(s/1024), where s is the word read as signed 32-bit and clamped to [-2097152, 2097151]. The result is sign-extended to 16 bits.
- R6: pt_tdata_o[15:0] is x, [31:16] is y and [47:32] is z.
- R7: While pt_tvalid_o is high and pt_tready_i is low, pt_tvalid_o stays high and pt_tdata_o stays unchanged on the next cycle.
- R8: Status bit 0 (busy) is 1 from the accepted start until the last beat is accepted. Bit 1 (done) is then 1 and stays 1 until the next accepted start clears it. Busy and done are never 1 together.
- R9: A start with a count of zero sets done on the same edge, never raises busy, and emits no beat.
- R10: A start written while busy is ignored. The beats, the beat total and fb_addr_o are those of the run already in progress, even if the count or base registers are rewritten during the run.
- R11: Only bits [13:0] of the count are used. The count is latched when the run starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s_awaddr_i | input | 4 | Register write address |
| s_awvalid_i | input | 1 | Write address valid |
| s_awready_o | output | 1 | Write address ready |
| s_wdata_i | input | 32 | Register write data |
| s_wvalid_i | input | 1 | Write data valid |
| s_wready_o | output | 1 | Write data ready |
| s_bvalid_o | output | 1 | Write response valid |
| s_bready_i | input | 1 | Write response ready |
| s_araddr_i | input | 4 | Register read address |
| s_arvalid_i | input | 1 | Read address valid |
| s_arready_o | output | 1 | Read address ready |
| s_rdata_o | output | 32 | Register read data |
| s_rvalid_o | output | 1 | Read data valid |
| s_rready_i | input | 1 | Read data ready |
| ram_en_o | output | 1 | Vertex RAM read enable |
| ram_addr_o | output | 10 | Vertex RAM word address |
| ram_rdata_i | input | 32 | Vertex RAM data, valid one cycle after the address |
| pt_tvalid_o | output | 1 | Point beat valid |
| pt_tready_i | input | 1 | Point beat ready |
| pt_tdata_o | output | 48 | Packed point {z, y, x} |
| fb_addr_o | output | 32 | Frame-buffer base of the current or last run |

## Verification
The hardest case to reach from the ports is a second start, together with rewritten count and base registers, landing in the middle of a run. A faulty design would restart or retarget the run there. The bench sends these writes right after a start, while the first beat is still held back by a low ready, and then drains the run with random ready. The saturation limits and the values on either side of them sit in the first RAM words. Other runs use random words and random backpressure, and one run sweeps the whole RAM so that the addresses wrap.

// File: rtl/vtx_pump_pkg.sv
package vtx_pump_pkg;
  localparam int WORD_W  = 32;
  localparam int INT_W   = 22;
  localparam int FRAC_W  = 10;
  localparam int COORD_W = 16;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_TAKE, ST_EMIT} seq_st_e;

  // clamp to INT_W signed integer range, then floor-divide by 2^FRAC_W
  function automatic logic [COORD_W-1:0] rescale(input logic [WORD_W-1:0] w);
    logic signed [WORD_W-1:0] v, hi, lo;
    hi = WORD_W'((64'sd1 <<< (INT_W-1)) - 1);
    lo = -hi - 1;
    v  = signed'(w);
    if (v > hi) v = hi;
    else if (v < lo) v = lo;
    v = v >>> FRAC_W;
    return v[COORD_W-1:0];
  endfunction
endpackage

// File: rtl/vtx_pump_regs.sv
module vtx_pump_regs #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] s_awaddr_i,
  input  logic              s_awvalid_i,
  output logic              s_awready_o,
  input  logic [DATA_W-1:0] s_wdata_i,
  input  logic              s_wvalid_i,
  output logic              s_wready_o,
  output logic              s_bvalid_o,
  input  logic              s_bready_i,
  input  logic [ADDR_W-1:0] s_araddr_i,
  input  logic              s_arvalid_i,
  output logic              s_arready_o,
  output logic [DATA_W-1:0] s_rdata_o,
  output logic              s_rvalid_o,
  input  logic              s_rready_i,
  input  logic              busy_i,
  input  logic              done_i,
  output logic [DATA_W-1:0] count_o,
  output logic [DATA_W-1:0] base_o,
  output logic              start_o
);
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_CNT  = 2'd1;
  localparam logic [1:0] SEL_BASE = 2'd2;

  logic wr_fire, rd_fire;
  logic [1:0] wsel, rsel;

  assign wsel    = s_awaddr_i[3:2];
  assign rsel    = s_araddr_i[3:2];
  assign wr_fire = s_awvalid_i && s_wvalid_i && !s_bvalid_o;
  assign rd_fire = s_arvalid_i && !s_rvalid_o;
  assign s_awready_o = wr_fire;
  assign s_wready_o  = wr_fire;
  assign s_arready_o = rd_fire;
  assign start_o     = wr_fire && (wsel == SEL_CTRL) && s_wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o    <= '0;
      base_o     <= '0;
      s_bvalid_o <= 1'b0;
    end else begin
      if (wr_fire) begin
        s_bvalid_o <= 1'b1;
        if (wsel == SEL_CNT)  count_o <= s_wdata_i;
        if (wsel == SEL_BASE) base_o  <= s_wdata_i;
      end else if (s_bready_i) begin
        s_bvalid_o <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_rvalid_o <= 1'b0;
      s_rdata_o  <= '0;
    end else if (rd_fire) begin
      s_rvalid_o <= 1'b1;
      unique case (rsel)
        SEL_CTRL: s_rdata_o <= {{(DATA_W-2){1'b0}}, done_i, busy_i};
        SEL_CNT:  s_rdata_o <= count_o;
        SEL_BASE: s_rdata_o <= base_o;
        default:  s_rdata_o <= '0;
      endcase
    end else if (s_rready_i) begin
      s_rvalid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/vtx_pump_seq.sv
module vtx_pump_seq
  import vtx_pump_pkg::*;
#(
  parameter int IDX_W  = 16,
  parameter int RAM_AW = 10
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [WORD_W-1:0]    count_i,
  input  logic [WORD_W-1:0]    base_i,
  output logic                 ram_en_o,
  output logic [RAM_AW-1:0]    ram_addr_o,
  input  logic [WORD_W-1:0]    ram_rdata_i,
  output logic                 pt_tvalid_o,
  input  logic                 pt_tready_i,
  output logic [3*COORD_W-1:0] pt_tdata_o,
  output logic [WORD_W-1:0]    fb_addr_o,
  output logic                 busy_o,
  output logic                 done_o
);
  localparam int CNT_W = IDX_W - 2;

  seq_st_e st;
  logic [IDX_W-1:0]   idx, end_idx, last_idx, idx_nxt;
  logic [COORD_W-1:0] cx, cy, cz;
  logic [1:0]         phase;

  assign end_idx = {count_i[CNT_W-1:0], 2'b00};
  assign idx_nxt = idx + IDX_W'(1);
  assign phase   = idx[1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st        <= ST_IDLE;
      idx       <= '0;
      last_idx  <= '0;
      cx        <= '0;
      cy        <= '0;
      cz        <= '0;
      fb_addr_o <= '0;
      done_o    <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (start_i) begin
          fb_addr_o <= base_i;
          idx       <= '0;
          last_idx  <= end_idx;
          if (end_idx == '0) done_o <= 1'b1;
          else begin
            done_o <= 1'b0;
            st     <= ST_READ;
          end
        end
        ST_READ: st <= ST_TAKE;
        ST_TAKE: begin
          unique case (phase)
            2'd0:    cx <= rescale(ram_rdata_i);
            2'd1:    cy <= rescale(ram_rdata_i);
            default: cz <= rescale(ram_rdata_i);
          endcase
          idx <= idx_nxt;
          st  <= (phase == 2'd2) ? ST_EMIT : ST_READ;
        end
        ST_EMIT: if (pt_tready_i) begin
          idx <= idx_nxt;
          if (idx_nxt == last_idx) begin
            done_o <= 1'b1;
            st     <= ST_IDLE;
          end else begin
            st <= ST_READ;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign ram_en_o    = (st == ST_READ);
  assign ram_addr_o  = idx[RAM_AW-1:0];
  assign pt_tvalid_o = (st == ST_EMIT);
  assign pt_tdata_o  = {cz, cy, cx};
  assign busy_o      = (st != ST_IDLE);
endmodule

// File: rtl/vtx_pump.sv
module vtx_pump
  import vtx_pump_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int IDX_W  = 16,
  parameter int RAM_AW = 10
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    s_awaddr_i,
  input  logic                 s_awvalid_i,
  output logic                 s_awready_o,
  input  logic [WORD_W-1:0]    s_wdata_i,
  input  logic                 s_wvalid_i,
  output logic                 s_wready_o,
  output logic                 s_bvalid_o,
  input  logic                 s_bready_i,
  input  logic [ADDR_W-1:0]    s_araddr_i,
  input  logic                 s_arvalid_i,
  output logic                 s_arready_o,
  output logic [WORD_W-1:0]    s_rdata_o,
  output logic                 s_rvalid_o,
  input  logic                 s_rready_i,
  output logic                 ram_en_o,
  output logic [RAM_AW-1:0]    ram_addr_o,
  input  logic [WORD_W-1:0]    ram_rdata_i,
  output logic                 pt_tvalid_o,
  input  logic                 pt_tready_i,
  output logic [3*COORD_W-1:0] pt_tdata_o,
  output logic [WORD_W-1:0]    fb_addr_o
);
  logic              busy, done, start;
  logic [WORD_W-1:0] count, base;

  vtx_pump_regs #(.ADDR_W(ADDR_W), .DATA_W(WORD_W)) i_regs (
    .clk_i, .rst_ni,
    .s_awaddr_i, .s_awvalid_i, .s_awready_o,
    .s_wdata_i, .s_wvalid_i, .s_wready_o,
    .s_bvalid_o, .s_bready_i,
    .s_araddr_i, .s_arvalid_i, .s_arready_o,
    .s_rdata_o, .s_rvalid_o, .s_rready_i,
    .busy_i(busy), .done_i(done),
    .count_o(count), .base_o(base), .start_o(start)
  );

  vtx_pump_seq #(.IDX_W(IDX_W), .RAM_AW(RAM_AW)) i_seq (
    .clk_i, .rst_ni,
    .start_i(start), .count_i(count), .base_i(base),
    .ram_en_o, .ram_addr_o, .ram_rdata_i,
    .pt_tvalid_o, .pt_tready_i, .pt_tdata_o,
    .fb_addr_o,
    .busy_o(busy), .done_o(done)
  );
endmodule

// File: rtl/vtx_pump_chk.sv
module vtx_pump_chk #(
  parameter int RAM_AW = 10,
  parameter int DW     = 48
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pt_tvalid_o,
  input logic              pt_tready_i,
  input logic [DW-1:0]     pt_tdata_o,
  input logic              ram_en_o,
  input logic [RAM_AW-1:0] ram_addr_o,
  input logic [31:0]       fb_addr_o,
  input logic              busy,
  input logic              done
);
  // R7
  hold_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pt_tvalid_o && !pt_tready_i |=> pt_tvalid_o && $stable(pt_tdata_o));

  // R4
  no_pad_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_en_o |-> ram_addr_o[1:0] != 2'b11);

  // R8
  busy_done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy && done));

  // R3
  fb_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && $past(busy) |-> $stable(fb_addr_o));

  // R8
  valid_in_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pt_tvalid_o || ram_en_o) |-> busy);

  // R8
  done_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(done) |-> busy);
endmodule

bind vtx_pump vtx_pump_chk #(.RAM_AW(RAM_AW), .DW(3*vtx_pump_pkg::COORD_W)) i_chk (
  .clk_i, .rst_ni, .pt_tvalid_o, .pt_tready_i, .pt_tdata_o,
  .ram_en_o, .ram_addr_o, .fb_addr_o, .busy, .done
);

// File: tb/test_vtx_pump.sv
module test_vtx_pump;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 1024;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic [3:0]  s_awaddr_i = '0, s_araddr_i = '0;
  logic        s_awvalid_i = 0, s_wvalid_i = 0, s_arvalid_i = 0;
  logic        s_bready_i = 1, s_rready_i = 1;
  logic [31:0] s_wdata_i = '0;
  logic        s_awready_o, s_wready_o, s_bvalid_o, s_arready_o, s_rvalid_o;
  logic [31:0] s_rdata_o, ram_rdata_i, fb_addr_o;
  logic        ram_en_o, pt_tvalid_o, pt_tready_i = 0;
  logic [9:0]  ram_addr_o;
  logic [47:0] pt_tdata_o;

  logic [31:0] mem [DEPTH];
  int checks = 0, failures = 0, ram_reads = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  vtx_pump i_vtx_pump (.*);

  always_ff @(posedge clk_i) begin
    if (ram_en_o) begin
      ram_rdata_i <= mem[ram_addr_o];
      ram_reads   <= ram_reads + 1;
    end
  end

  function automatic logic [15:0] exp_coord(logic [31:0] w);
    longint v = longint'(signed'(w));
    if (v > 2097151) v = 2097151;
    if (v < -2097152) v = -2097152;
    if (v < 0) v = -((-v + 1023) / 1024);
    else v = v / 1024;
    return v[15:0];
  endfunction

  function automatic logic [47:0] exp_beat(int k);
    int a = (4*k) % DEPTH;
    return {exp_coord(mem[a+2]), exp_coord(mem[a+1]), exp_coord(mem[a])};
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic axi_write(logic [3:0] a, logic [31:0] d);
    @(negedge clk_i);
    s_awaddr_i = a; s_wdata_i = d; s_awvalid_i = 1; s_wvalid_i = 1;
    #1;
    while (!s_awready_o) begin @(negedge clk_i); #1; end
    @(negedge clk_i);
    s_awvalid_i = 0; s_wvalid_i = 0;
  endtask

  task automatic axi_read(logic [3:0] a, output logic [31:0] d);
    @(negedge clk_i);
    s_araddr_i = a; s_arvalid_i = 1;
    #1;
    while (!s_arready_o) begin @(negedge clk_i); #1; end
    @(negedge clk_i);
    s_arvalid_i = 0;
    d = s_rdata_o;
  endtask

  // run n vertices, ready low with probability bp percent
  task automatic run(int n, int bp, bit poke);
    logic [31:0] st, base;
    logic [47:0] held;
    bit was_held = 0;
    int got = 0, guard = 0, reads0;
    base = $urandom;
    axi_write(4'h4, n);
    axi_write(4'h8, base);
    reads0 = ram_reads;
    pt_tready_i = 0;
    axi_write(4'h0, 1);
    check(fb_addr_o == base, "R3 fb_addr on start", fb_addr_o, base);
    axi_read(4'h0, st);
    check(st == 1, "R8 busy during run", st, 1);
    if (poke) begin
      axi_write(4'h4, n + 7);
      axi_write(4'h8, ~base);
      axi_write(4'h0, 1);
      check(fb_addr_o == base, "R10 start while busy ignored", fb_addr_o, base);
    end
    while (got < n && guard < 20000) begin
      @(negedge clk_i);
      pt_tready_i = ($urandom % 100) >= bp;
      #1;
      guard++;
      if (pt_tvalid_o) begin
        if (was_held) check(pt_tdata_o == held, "R7 beat held", pt_tdata_o, held);
        if (pt_tready_i) begin
          check(pt_tdata_o == exp_beat(got), "R4 R5 R6 beat value", pt_tdata_o, exp_beat(got));
          got++;
          was_held = 0;
        end else begin
          held = pt_tdata_o;
          was_held = 1;
        end
      end
    end
    check(got == n, "R4 beat total", got, n);
    pt_tready_i = 1;
    repeat (12) begin
      @(negedge clk_i);
      if (pt_tvalid_o) check(0, "R4 R10 no extra beat", 1, 0);
    end
    check(ram_reads - reads0 == 3*n, "R4 read total", ram_reads - reads0, 3*n);
    axi_read(4'h0, st);
    check(st == 2, "R8 done after run", st, 2);
    check(fb_addr_o == base, "R3 fb_addr held", fb_addr_o, base);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      check(0, "watchdog", 0, 1);
      summary();
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5eed));
    for (int i = 0; i < DEPTH; i++)
      case ($urandom % 4)
        0:       mem[i] = $urandom;
        default: mem[i] = 32'($signed($urandom % 4194304) - 2097152) * 2;
      endcase
    mem[0] = 32'd2097151;  mem[1] = 32'd2097152;  mem[2] = 32'hFFE0_0000;
    mem[4] = 32'hFFDF_FFFF; mem[5] = 32'h7FFF_FFFF; mem[6] = 32'h8000_0000;
    mem[8] = 32'hFFFF_FFFF; mem[9] = 32'd1023;    mem[10] = 32'hFFFF_FC00;
    mem[3] = 32'hDEAD_0003; mem[7] = 32'hDEAD_0007;

    repeat (3) @(negedge clk_i);
    // R1
    check(pt_tvalid_o == 0 && ram_en_o == 0, "R1 outputs in reset", {pt_tvalid_o, ram_en_o}, 0);
    check(fb_addr_o == 0, "R1 fb_addr reset", fb_addr_o, 0);
    rst_ni = 1;
    axi_read(4'h0, d);
    check(d == 0, "R1 status reset", d, 0);

    // R2
    axi_write(4'h4, 32'hA5C3_0F17);
    axi_write(4'h8, 32'h1234_5678);
    axi_read(4'h4, d);
    check(d == 32'hA5C3_0F17, "R2 count readback", d, 32'hA5C3_0F17);
    axi_read(4'h8, d);
    check(d == 32'h1234_5678, "R2 base readback", d, 32'h1234_5678);

    // R5 R6 corner words, no backpressure
    check(exp_coord(32'h8000_0000) == 16'hF800, "R5 bench model low clamp", exp_coord(32'h8000_0000), 16'hF800);
    run(3, 0, 0);
    run(40, 40, 0);
    // R10 R11 extra start and register rewrites mid-run
    run(25, 30, 1);
    // R4 full depth sweep with wrap
    run(300, 20, 0);

    // R9 zero count
    axi_write(4'h4, 0);
    axi_write(4'h0, 1);
    axi_read(4'h0, d);
    check(d == 2, "R9 zero count done", d, 2);
    repeat (20) begin
      @(negedge clk_i);
      if (pt_tvalid_o || ram_en_o) check(0, "R9 zero count no activity", 1, 0);
    end

    // R11 only low 14 bits of count used: 16384+2 runs 2 vertices
    run(2, 10, 0);
    axi_write(4'h4, 32'h0000_4002);
    d = ram_reads;
    axi_write(4'h0, 1);
    pt_tready_i = 1;
    repeat (60) @(negedge clk_i);
    check(ram_reads - d == 6, "R11 count truncated", ram_reads - d, 6);

    finished = 1;
    summary();
  end
endmodule